// File: doc/BRIEF.md
# Indirect Register Access Host Port

This block is the I/O-mapped host side of a peripheral. It gives the host a window of sixteen byte addresses, and through that window the host reaches a 4K byte-address internal register space. The host first writes a pointer word at window offset 0Ah. The low twelve bits of that word select the internal address, and the top bit asks for automatic advance. The host then moves data through two data ports. A 16-bit transfer uses port 0 at offset 0Ch. A 32-bit transfer is done as two 16-bit host cycles: the low word goes through port 0, then the high word goes through port 1 at offset 0Eh.

The host strobes are sampled in the block clock domain. Each falling edge of IOR or IOW that hits a mapped offset causes exactly one access. For a data port, that access is a one-cycle read or write strobe on the internal register bus, with registered address and write data. Read data comes back from the register bus, or from the pointer itself, and is held on the host read bus until the next mapped read. The interrupt status queue and every other register are ordinary internal addresses and need no special handling.

Top module: `host_reg_port`

## Requirements
- R1: An access happens only when a strobe falls while aen_ni is 0 and sa_i lies in [IO_BASE, IO_BASE+15] at offset 0Ah, 0Ch or 0Eh. Any other strobe causes no internal strobe, leaves the pointer unchanged, and leaves host_rdata_o unchanged.
- R2: A write at offset 0Ah stores bits 11:0 as the address and bit 15 as the advance flag. Bits 14:12 are accepted but stored as 0. A read at 0Ah returns the stored pointer without changing it.
- R3: A write at offset 0Ch drives the host data on reg_wdata_o and drives the pointer address on reg_addr_o, with reg_wr_o high for one cycle in the clock after the IOW falling edge.
- R4: A read at offset 0Ch or 0Eh raises reg_rd_o for one cycle. The reg_rdata_i value is returned on host_rdata_o two clocks after the IOR falling edge and is held until the next mapped read.
- R5: When the pointer flag bit 15 is 1, each port 0 access advances the pointer address by 2. When the flag is 0, the pointer does not move.
- R6: A port 1 access that follows a port 0 access, with no pointer write or port 1 access in between, targets the port 0 address + 2. With the flag set, the pointer then rests at the port 0 address + 4.
- R7: A port 1 access without a preceding port 0 access targets the pointer address + 2. With the flag set, it moves the pointer to its address + 4.
- R8: All address arithmetic is modulo 4096. For example, 0FFEh + 2 gives 000h, both for advance and for port 1 targets.
- R9: A host strobe held low for many cycles produces exactly one internal strobe. reg_rd_o and reg_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_i | input | 16 | Host I/O byte address |
| aen_ni | input | 1 | Address enable, active low (low = I/O cycle for this device) |
| ior_ni | input | 1 | Host read strobe, active low |
| iow_ni | input | 1 | Host write strobe, active low |
| hd_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, held between reads |
| reg_addr_o | output | 12 | Internal register byte address |
| reg_wdata_o | output | 16 | Internal register write data |
| reg_rdata_i | input | 16 | Internal register read data, combinational from reg_addr_o |
| reg_rd_o | output | 1 | One-cycle internal read strobe |
| reg_wr_o | output | 1 | One-cycle internal write strobe |

## Verification
The hardest states to reach are the pairing state and the wrap. A port 1 access must be told apart depending on whether a port 0 access armed it, and whether a pointer write or a stray cycle came in between, while the pointer sits near the top of the space. Random sequences mix pointer writes that have random reserved bits, port 0 and port 1 reads and writes, and cycles that miss the window, so that armed, unarmed and wrapping cases interleave. Directed cases place the pointer at 0FFEh and run a full pair with and without advance.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int unsigned WIN_W = 4;
  localparam logic [WIN_W-1:0] OFF_PTR = 4'hA;
  localparam logic [WIN_W-1:0] OFF_DP0 = 4'hC;
  localparam logic [WIN_W-1:0] OFF_DP1 = 4'hE;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PTR,
    SEL_DP0,
    SEL_DP1
  } port_sel_e;
endpackage

// File: rtl/hrp_decode.sv
module hrp_decode
  import hrp_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'h0300
) (
  input  logic [15:0] sa_i,
  input  logic        aen_ni,
  output port_sel_e   sel_o
);
  logic win_hit;
  assign win_hit = !aen_ni && (sa_i[15:WIN_W] == IO_BASE[15:WIN_W]);

  always_comb begin
    sel_o = SEL_NONE;
    if (win_hit) begin
      unique case (sa_i[WIN_W-1:0])
        OFF_PTR: sel_o = SEL_PTR;
        OFF_DP0: sel_o = SEL_DP0;
        OFF_DP1: sel_o = SEL_DP1;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hrp_strobe.sv
module hrp_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ior_ni,
  input  logic iow_ni,
  output logic rd_start_o,
  output logic wr_start_o
);
  logic ior_q, iow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ior_q <= 1'b1;
      iow_q <= 1'b1;
    end else begin
      ior_q <= ior_ni;
      iow_q <= iow_ni;
    end
  end

  // write wins if both fall together
  assign wr_start_o = iow_q && !iow_ni;
  assign rd_start_o = ior_q && !ior_ni && !wr_start_o;
endmodule

// File: rtl/hrp_pointer.sv
module hrp_pointer #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_wr_i,
  input  logic          auto_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dp0_acc_i,
  input  logic          dp1_acc_i,
  output logic [DW-1:0] ptr_o,
  output logic [AW-1:0] tgt_addr_o
);
  localparam int unsigned RSV_W = DW - 1 - AW;
  localparam logic [AW-1:0] WORD = AW'(2);
  localparam logic [AW-1:0] DWORD = AW'(4);

  logic          auto_q, armed_q;
  logic [AW-1:0] addr_q, base_q, pair_base;

  assign pair_base  = armed_q ? base_q : addr_q;
  assign tgt_addr_o = dp1_acc_i ? pair_base + WORD : addr_q;
  assign ptr_o      = {auto_q, {RSV_W{1'b0}}, addr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      armed_q <= 1'b0;
    end else if (ptr_wr_i) begin
      auto_q  <= auto_i;
      addr_q  <= addr_i;
      armed_q <= 1'b0;
    end else if (dp0_acc_i) begin
      base_q  <= addr_q;
      armed_q <= 1'b1;
      if (auto_q) addr_q <= addr_q + WORD;
    end else if (dp1_acc_i) begin
      armed_q <= 1'b0;
      if (auto_q) addr_q <= pair_base + DWORD;
    end
  end

  a_r5_auto_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp0_acc_i && !ptr_wr_i && auto_q) |=> (addr_q == $past(addr_q) + WORD));

  a_r5_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dp0_acc_i || dp1_acc_i) && !ptr_wr_i && !auto_q) |=> $stable(addr_q));

  a_r6_pair_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp1_acc_i && !ptr_wr_i && armed_q && auto_q) |=> (addr_q == $past(base_q) + DWORD));
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'h0300,
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   sa_i,
  input  logic          aen_ni,
  input  logic          ior_ni,
  input  logic          iow_ni,
  input  logic [DW-1:0] hd_i,
  output logic [DW-1:0] host_rdata_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_rd_o,
  output logic          reg_wr_o
);
  port_sel_e     sel;
  logic          rd_start, wr_start, any_start, dp_sel;
  logic          ptr_wr, dp0_acc, dp1_acc;
  logic [DW-1:0] ptr_val;
  logic [AW-1:0] tgt_addr;

  hrp_decode #(.IO_BASE(IO_BASE)) u_decode (
    .sa_i   (sa_i),
    .aen_ni (aen_ni),
    .sel_o  (sel)
  );

  hrp_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ior_ni     (ior_ni),
    .iow_ni     (iow_ni),
    .rd_start_o (rd_start),
    .wr_start_o (wr_start)
  );

  assign any_start = rd_start || wr_start;
  assign dp_sel    = (sel == SEL_DP0) || (sel == SEL_DP1);
  assign ptr_wr    = wr_start && (sel == SEL_PTR);
  assign dp0_acc   = any_start && (sel == SEL_DP0);
  assign dp1_acc   = any_start && (sel == SEL_DP1);

  hrp_pointer #(.AW(AW), .DW(DW)) u_pointer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_wr_i   (ptr_wr),
    .auto_i     (hd_i[DW-1]),
    .addr_i     (hd_i[AW-1:0]),
    .dp0_acc_i  (dp0_acc),
    .dp1_acc_i  (dp1_acc),
    .ptr_o      (ptr_val),
    .tgt_addr_o (tgt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rd_o     <= 1'b0;
      reg_wr_o     <= 1'b0;
      reg_addr_o   <= '0;
      reg_wdata_o  <= '0;
      host_rdata_o <= '0;
    end else begin
      reg_rd_o <= rd_start && dp_sel;
      reg_wr_o <= wr_start && dp_sel;
      if (any_start && dp_sel) reg_addr_o <= tgt_addr;
      if (wr_start && dp_sel) reg_wdata_o <= hd_i;
      if (rd_start && (sel == SEL_PTR)) host_rdata_o <= ptr_val;
      else if (reg_rd_o) host_rdata_o <= reg_rdata_i;
    end
  end

  a_r9_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));

  a_r9_wr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r9_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r1_wr_needs_aen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(!aen_ni && !iow_ni));
endmodule

// File: tb/host_reg_port_tb.sv
`timescale 1ns/1ps
module host_reg_port_tb;
  localparam logic [15:0] BASE = 16'h0300;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sa_i = 16'h0000;
  logic        aen_ni = 1'b1, ior_ni = 1'b1, iow_ni = 1'b1;
  logic [15:0] hd_i = 16'h0000;
  logic [15:0] host_rdata_o, reg_wdata_o, reg_rdata_i;
  logic [11:0] reg_addr_o;
  logic        reg_rd_o, reg_wr_o;

  always #4 clk = ~clk;

  host_reg_port #(.IO_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sa_i(sa_i), .aen_ni(aen_ni),
    .ior_ni(ior_ni), .iow_ni(iow_ni), .hd_i(hd_i),
    .host_rdata_o(host_rdata_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o)
  );

  // register space seen by the block
  logic [15:0] slave_mem [2048];
  logic [15:0] exp_mem   [2048];
  assign reg_rdata_i = slave_mem[reg_addr_o[11:1]];

  int wr_cnt = 0, rd_cnt = 0;
  logic [11:0] last_addr;
  logic [15:0] last_wdata;
  always @(negedge clk) begin
    if (reg_wr_o) begin
      slave_mem[reg_addr_o[11:1]] = reg_wdata_o;
      last_addr = reg_addr_o; last_wdata = reg_wdata_o; wr_cnt++;
    end
    if (reg_rd_o) begin
      last_addr = reg_addr_o; rd_cnt++;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench pointer model
  bit          m_auto = 0, m_armed = 0;
  logic [11:0] m_addr = '0, m_base = '0;

  function automatic logic [15:0] m_ptr();
    return {m_auto, 3'b000, m_addr};
  endfunction

  task automatic acc(input bit wr, input bit aen, input logic [15:0] sa, input logic [15:0] d);
    logic [3:0]  off = sa[3:0];
    bit          hit = !aen && (sa[15:4] == BASE[15:4]) && (off == 4'hA || off == 4'hC || off == 4'hE);
    bit          dp = hit && (off != 4'hA);
    int          wc0 = wr_cnt, rc0 = rd_cnt;
    logic [11:0] pb, tgt, nxt;
    logic [15:0] rd0 = host_rdata_o;
    string       tag;
    pb  = m_armed ? m_base : m_addr;
    tgt = (off == 4'hE) ? pb + 12'd2 : m_addr;
    tag = (off == 4'hE) ? (m_armed ? "R6" : "R7") : "R3";
    if (dp && (tgt < m_addr || m_addr >= 12'hFFC)) tag = "R8";
    @(negedge clk);
    sa_i = sa; aen_ni = aen; hd_i = d;
    if (wr) iow_ni = 1'b0; else ior_ni = 1'b0;
    repeat (4) @(negedge clk);
    check((wr_cnt - wc0) == ((dp && wr) ? 1 : 0), "R9 wr strobe count", wr_cnt - wc0, (dp && wr) ? 1 : 0);
    check((rd_cnt - rc0) == ((dp && !wr) ? 1 : 0), "R9 rd strobe count", rd_cnt - rc0, (dp && !wr) ? 1 : 0);
    if (dp) check(last_addr == tgt, tag, last_addr, tgt);
    if (dp && wr) begin
      check(last_wdata == d, "R3 wdata", last_wdata, d);
      exp_mem[tgt[11:1]] = d;
    end
    if (dp && !wr) check(host_rdata_o == exp_mem[tgt[11:1]], "R4 read data", host_rdata_o, exp_mem[tgt[11:1]]);
    if (hit && off == 4'hA && !wr) check(host_rdata_o == m_ptr(), "R2 pointer read", host_rdata_o, m_ptr());
    if (!hit || (wr && !dp)) check(host_rdata_o == rd0, "R1 rdata untouched", host_rdata_o, rd0);
    iow_ni = 1'b1; ior_ni = 1'b1; aen_ni = 1'b1;
    repeat (2) @(negedge clk);
    if (hit) begin
      if (off == 4'hA && wr) begin
        m_auto = d[15]; m_addr = d[11:0]; m_armed = 0;
      end else if (off == 4'hC) begin
        m_base = m_addr; m_armed = 1;
        if (m_auto) m_addr = m_addr + 12'd2;
      end else if (off == 4'hE) begin
        nxt = pb + 12'd4; m_armed = 0;
        if (m_auto) m_addr = nxt;
      end
    end
  endtask

  task automatic ptr_is(input logic [15:0] e, input string req);
    acc(0, 0, BASE + 16'hA, 16'h0);
    check(host_rdata_o == e, req, host_rdata_o, e);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin slave_mem[i] = '0; exp_mem[i] = '0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(host_rdata_o == 16'h0 && !reg_rd_o && !reg_wr_o, "R1 reset outputs", {host_rdata_o, 14'b0, reg_rd_o, reg_wr_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    ptr_is(16'h0000, "R2 reset pointer");

    // R2 reserved bits masked
    acc(1, 0, BASE + 16'hA, 16'hFFFE);
    ptr_is(16'h8FFE, "R2 reserved masked");
    // R8 wrap on port 0 advance
    acc(1, 0, BASE + 16'hC, 16'hA5A5);
    ptr_is(16'h8000, "R8 wrap advance");
    // R6 + R8 pair across the top
    acc(1, 0, BASE + 16'hA, 16'h8FFE);
    acc(1, 0, BASE + 16'hC, 16'h1111);
    acc(1, 0, BASE + 16'hE, 16'h2222);
    ptr_is(16'h8002, "R6 pair end pointer");
    acc(1, 0, BASE + 16'hA, 16'h0FFE);
    acc(0, 0, BASE + 16'hC, 16'h0);
    acc(0, 0, BASE + 16'hE, 16'h0);
    ptr_is(16'h0FFE, "R5 fixed pointer");
    // R7 unpaired port 1
    acc(1, 0, BASE + 16'hA, 16'h8010);
    acc(1, 0, BASE + 16'hE, 16'h3333);
    ptr_is(16'h8014, "R7 unpaired advance");
    // R1 strays
    acc(1, 1, BASE + 16'hC, 16'hDEAD);
    acc(1, 0, BASE + 16'h4, 16'hDEAD);
    acc(1, 0, BASE + 16'h10C, 16'hDEAD);
    acc(0, 1, BASE + 16'hC, 16'h0);
    ptr_is(16'h8014, "R1 stray ignored");

    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      case (sel)
        0: acc(1, 0, BASE + 16'hA, ($urandom_range(0, 3) == 0) ? {d[15:12], 12'hFFC} : d);
        1, 2: acc(1, 0, BASE + 16'hC, d);
        3: acc(0, 0, BASE + 16'hC, d);
        4, 5: acc(1, 0, BASE + 16'hE, d);
        6: acc(0, 0, BASE + 16'hE, d);
        7: acc(0, 0, BASE + 16'hA, d);
        8: acc($urandom_range(0, 1) == 1, 1, BASE + {12'h0, 2'($urandom_range(1, 3)), 2'b10}, d);
        default: acc($urandom_range(0, 1) == 1, 0,
                     ($urandom_range(0, 1) == 1) ? BASE + {12'h0, d[3:0] & 4'h9} : d ^ 16'h4000 | 16'h4000, d);
      endcase
    end
    ptr_is(m_ptr(), "R5 final pointer");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule